// File: doc/BRIEF.md
# Multi-channel sample FIFO refill sequencer

The block is a request-driven sequencer that serves eight audio channels from one shared single-port synchronous RAM. Each channel owns a sixteen-entry sample FIFO and a small parameter region in that RAM. The parameter region holds a status word (FIFO read pointer, FIFO write pointer, a pointer-match flag called full, and a span toggle), a 24-bit DMA address, and two last-address pairs. The span toggle selects which pair is active. Every RAM access takes one state of the sequencer.

A poll names a channel. A plain poll reads the sample at the channel's read pointer into an output latch and writes back an updated status word. A refill poll runs a DMA cycle, in this order:

1. Fetch the DMA address, low word first. An address strobe marks the high-word fetch.
2. Optionally read a sample for the channel.
3. Read the active last address.
4. Ask an external sample source for the word at the DMA address.
5. Rewrite the status word.
6. Store the new word into the FIFO.
7. Write back the DMA address plus one.

When the fetched address equals the last address, the toggle flips. A channel/update vector is then posted for the CPU, unless an earlier vector has not yet been read.

Before use, a CPU fills the RAM through a simple write port, which is accepted only while the sequencer is idle. The CPU reads the vector and clears the pending interrupt with a one-cycle read strobe.

Top module: `sds_seq`

## Requirements
- R1: After reset, busy, irq, smp_valid, src_req and mem_strobe are 0, and vec_data, smp_data and stat_word are all zero.
- R2: RAM address map is {channel[2:0], region, index[3:0]}. Region 0 is the FIFO, indexed by pointer. Region 1 holds: index 0 status, 1 DMA address low 16 bits, 2 DMA address high (bits 7:0 used), 3/4 last address low/high for toggle 0, 5/6 last address low/high for toggle 1. A plain poll (poll_dma=0) loads the FIFO word at the read pointer into smp_data and pulses smp_valid once.
- R3: The status word is laid out as follows: read pointer in bits 3:0, write pointer in bits 7:4, full in bit 8, toggle in bit 9. After a plain poll, the read pointer is incremented modulo 16, the write pointer and toggle are unchanged, and full is 1 exactly when the new pointers are equal. The result is stored to RAM and shown on stat_word.
- R4: A refill poll presents the 24-bit address {high[7:0], low} on src_addr while src_req is high. mem_strobe is high for exactly one cycle per refill poll and never during a plain poll.
- R5: Within a refill poll, the FIFO word at the read pointer is loaded into smp_data with one smp_valid pulse only when poll_need=1. When poll_need=0, smp_valid stays low.
- R6: The refill compares the DMA address with the last-address pair selected by the current toggle. Equality marks a last access.
- R7: After a refill, the write pointer is incremented, the read pointer is incremented by poll_need, and full is set from pointer equality.
- R8: The word taken from src_data on src_ack is stored at the FIFO entry of the write pointer held before the refill. The DMA address plus one (mod 2^24) is written back, with the high word's bits 15:8 zero.
- R9: A last access inverts the status toggle.
- R10: The vector has channel in bits 4:2, the new toggle in bit 1, and all other bits zero. On a last access with irq low, the vector is latched and irq is set. With irq already high, the vector is unchanged. vec_rd clears irq.
- R11: cpu_ack is high, and the write takes effect, only when cpu_we is high while busy is low. A CPU write has priority over a poll request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_req | input | 1 | Poll request, taken when idle and no CPU write |
| poll_ch | input | 3 | Channel of the poll |
| poll_dma | input | 1 | 1 runs a refill cycle |
| poll_need | input | 1 | Refill also reads a sample |
| busy | output | 1 | Sequencer not idle |
| smp_data | output | 16 | Latched output sample |
| smp_valid | output | 1 | One-cycle pulse on new sample |
| stat_word | output | 10 | Last status word written |
| mem_strobe | output | 1 | Marks the high address fetch |
| src_req | output | 1 | Sample source request |
| src_addr | output | 24 | Source address |
| src_ack | input | 1 | Source acknowledge with data |
| src_data | input | 16 | Source sample |
| cpu_we | input | 1 | CPU RAM write |
| cpu_addr | input | 8 | CPU RAM address |
| cpu_wdata | input | 16 | CPU RAM data |
| cpu_ack | output | 1 | CPU write accepted |
| vec_rd | input | 1 | CPU vector read, clears irq |
| vec_data | output | 8 | Interrupt vector |
| irq | output | 1 | Interrupt pending |

## Verification
The hardest case is a second last access that arrives while the first vector is still unread. Reaching it needs one channel whose two span pairs are set to consecutive addresses, so that two back-to-back refills both hit. The bench sets those two pairs through the CPU port and runs two refills without reading the vector in between. It then checks that the toggle flipped twice while the vector stayed the same. A CPU write is also forced in the middle of a poll, and later FIFO reads show whether it leaked into the RAM.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_P_SMP, ST_P_WB,
    ST_A_LO, ST_A_HI, ST_A_SMP, ST_A_LLO, ST_A_LHI,
    ST_A_REQ, ST_A_STAT, ST_A_DATA, ST_A_ALO, ST_A_AHI
  } sds_state_e;

  localparam int unsigned IDX_STAT = 0;
  localparam int unsigned IDX_DLO  = 1;
  localparam int unsigned IDX_DHI  = 2;
  localparam int unsigned IDX_LLO  = 3;  // +2 when toggle set, high word follows low
endpackage

// File: rtl/sds_ram.sv
module sds_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end

  always_comb begin
    assert (!(we && re)) else $error("assert_one_access_R2: read and write together");
  end
endmodule

// File: rtl/sds_vector.sv
module sds_vector #(
  parameter int CHW = 3,
  parameter int VW  = 8
) (
  input  logic           clk,
  input  logic           rst_i,
  input  logic           post,
  input  logic [CHW-1:0] ch,
  input  logic           upd,
  input  logic           clr,
  output logic [VW-1:0]  vec,
  output logic           irq
);
  logic [VW-1:0] vec_q, vec_d;
  logic          irq_q, irq_d;
  logic          take;

  assign take = post && !irq_q;

  always_comb begin
    vec_d = vec_q;
    irq_d = irq_q;
    if (clr) irq_d = 1'b0;
    if (take) begin
      vec_d          = '0;
      vec_d[1]       = upd;
      vec_d[2+:CHW]  = ch;
      irq_d          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (take) vec_q <= vec_d;
      irq_q <= irq_d;
    end
  end

  assign vec = vec_q;
  assign irq = irq_q;

  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (irq_q && !clr) |=> $stable(vec_q));
  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(irq_q) |-> $past(post));
endmodule

// File: rtl/sds_seq.sv
module sds_seq
  import sds_pkg::*;
#(
  parameter int NCH = 8,
  parameter int PW  = 4,
  parameter int DW  = 16,
  parameter int DAW = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   poll_req,
  input  logic [$clog2(NCH)-1:0] poll_ch,
  input  logic                   poll_dma,
  input  logic                   poll_need,
  output logic                   busy,
  output logic [DW-1:0]          smp_data,
  output logic                   smp_valid,
  output logic [2*PW+1:0]        stat_word,
  output logic                   mem_strobe,
  output logic                   src_req,
  output logic [DAW-1:0]         src_addr,
  input  logic                   src_ack,
  input  logic [DW-1:0]          src_data,
  input  logic                   cpu_we,
  input  logic [$clog2(NCH)+PW:0] cpu_addr,
  input  logic [DW-1:0]          cpu_wdata,
  output logic                   cpu_ack,
  input  logic                   vec_rd,
  output logic [7:0]             vec_data,
  output logic                   irq
);
  localparam int CHW = $clog2(NCH);
  localparam int RAW = CHW + 1 + PW;
  localparam int SW  = 2 * PW + 2;
  localparam int HW  = DAW - DW;
  localparam int TOG = SW - 1;
  localparam int FUL = SW - 2;

  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  sds_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic           dma_q, dma_d, need_q, need_d, last_hit_q, last_hit_d;
  logic [SW-1:0]  stat_q, stat_d, stat_n;
  logic [DAW-1:0] addr_q, addr_d, addr_inc;
  logic [DW-1:0]  llo_q, llo_d, sample_q, sample_d, smp_q, smp_d;
  logic           smp_v_q, smp_v_d;
  logic           ram_we, ram_re, post;
  logic [RAW-1:0] ram_addr;
  logic [DW-1:0]  ram_wdata, ram_rdata;
  logic [PW-1:0]  rd_n, wr_n, llo_idx;

  function automatic logic [RAW-1:0] fifo_a(input logic [CHW-1:0] c, input logic [PW-1:0] p);
    return {c, 1'b0, p};
  endfunction
  function automatic logic [RAW-1:0] par_a(input logic [CHW-1:0] c, input logic [PW-1:0] i);
    return {c, 1'b1, i};
  endfunction

  // status update shared by plain and refill polls
  always_comb begin
    rd_n   = stat_q[PW-1:0] + PW'((dma_q && !need_q) ? 0 : 1);
    wr_n   = stat_q[2*PW-1:PW] + PW'(dma_q ? 1 : 0);
    stat_n = {stat_q[TOG] ^ (dma_q && last_hit_q), rd_n == wr_n, wr_n, rd_n};
  end

  assign addr_inc = addr_q + DAW'(1);
  assign llo_idx  = PW'(IDX_LLO) + (stat_q[TOG] ? PW'(2) : PW'(0));

  always_comb begin
    state_d = state_q;  ch_d = ch_q;  dma_d = dma_q;  need_d = need_q;
    stat_d = stat_q;  addr_d = addr_q;  llo_d = llo_q;  last_hit_d = last_hit_q;
    sample_d = sample_q;  smp_d = smp_q;  smp_v_d = 1'b0;
    ram_we = 1'b0;  ram_re = 1'b0;  ram_addr = '0;  ram_wdata = '0;
    post = 1'b0;  mem_strobe = 1'b0;  src_req = 1'b0;  cpu_ack = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_we) begin
          cpu_ack = 1'b1;  ram_we = 1'b1;  ram_addr = cpu_addr;  ram_wdata = cpu_wdata;
        end else if (poll_req) begin
          ch_d = poll_ch;  dma_d = poll_dma;  need_d = poll_need;  last_hit_d = 1'b0;
          ram_re = 1'b1;  ram_addr = par_a(poll_ch, PW'(IDX_STAT));
          state_d = poll_dma ? ST_A_LO : ST_P_SMP;
        end
      end
      ST_P_SMP: begin
        stat_d = ram_rdata[SW-1:0];
        ram_re = 1'b1;  ram_addr = fifo_a(ch_q, ram_rdata[PW-1:0]);
        state_d = ST_P_WB;
      end
      ST_P_WB: begin
        smp_d = ram_rdata;  smp_v_d = 1'b1;  stat_d = stat_n;
        ram_we = 1'b1;  ram_addr = par_a(ch_q, PW'(IDX_STAT));  ram_wdata = DW'(stat_n);
        state_d = ST_IDLE;
      end
      ST_A_LO: begin
        stat_d = ram_rdata[SW-1:0];
        ram_re = 1'b1;  ram_addr = par_a(ch_q, PW'(IDX_DLO));
        state_d = ST_A_HI;
      end
      ST_A_HI: begin
        addr_d[DW-1:0] = ram_rdata;  mem_strobe = 1'b1;
        ram_re = 1'b1;  ram_addr = par_a(ch_q, PW'(IDX_DHI));
        state_d = ST_A_SMP;
      end
      ST_A_SMP: begin
        addr_d[DAW-1:DW] = ram_rdata[HW-1:0];
        ram_re = need_q;  ram_addr = fifo_a(ch_q, stat_q[PW-1:0]);
        state_d = ST_A_LLO;
      end
      ST_A_LLO: begin
        if (need_q) begin
          smp_d = ram_rdata;  smp_v_d = 1'b1;
        end
        ram_re = 1'b1;  ram_addr = par_a(ch_q, llo_idx);
        state_d = ST_A_LHI;
      end
      ST_A_LHI: begin
        llo_d = ram_rdata;
        ram_re = 1'b1;  ram_addr = par_a(ch_q, llo_idx + PW'(1));
        state_d = ST_A_REQ;
      end
      ST_A_REQ: begin
        src_req = 1'b1;
        if (src_ack) begin
          sample_d   = src_data;
          last_hit_d = (addr_q == {ram_rdata[HW-1:0], llo_q});
          state_d    = ST_A_STAT;
        end
      end
      ST_A_STAT: begin
        stat_d = stat_n;  post = last_hit_q;
        ram_we = 1'b1;  ram_addr = par_a(ch_q, PW'(IDX_STAT));  ram_wdata = DW'(stat_n);
        state_d = ST_A_DATA;
      end
      ST_A_DATA: begin
        ram_we = 1'b1;  ram_addr = fifo_a(ch_q, stat_q[2*PW-1:PW] - PW'(1));
        ram_wdata = sample_q;
        state_d = ST_A_ALO;
      end
      ST_A_ALO: begin
        ram_we = 1'b1;  ram_addr = par_a(ch_q, PW'(IDX_DLO));  ram_wdata = addr_inc[DW-1:0];
        state_d = ST_A_AHI;
      end
      ST_A_AHI: begin
        ram_we = 1'b1;  ram_addr = par_a(ch_q, PW'(IDX_DHI));
        ram_wdata = DW'(addr_inc[DAW-1:DW]);
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;  ch_q <= '0;  dma_q <= 1'b0;  need_q <= 1'b0;
      stat_q <= '0;  addr_q <= '0;  llo_q <= '0;  last_hit_q <= 1'b0;
      sample_q <= '0;  smp_q <= '0;  smp_v_q <= 1'b0;
    end else begin
      state_q <= state_d;  ch_q <= ch_d;  dma_q <= dma_d;  need_q <= need_d;
      stat_q <= stat_d;  addr_q <= addr_d;  llo_q <= llo_d;  last_hit_q <= last_hit_d;
      sample_q <= sample_d;  smp_q <= smp_d;  smp_v_q <= smp_v_d;
    end
  end

  sds_ram #(.AW(RAW), .DW(DW)) i_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  sds_vector #(.CHW(CHW), .VW(8)) i_vec (
    .clk(clk), .rst_i(rst_i), .post(post), .ch(ch_q), .upd(stat_n[TOG]),
    .clr(vec_rd), .vec(vec_data), .irq(irq)
  );

  assign busy      = (state_q != ST_IDLE);
  assign smp_data  = smp_q;
  assign smp_valid = smp_v_q;
  assign stat_word = stat_q;
  assign src_addr  = addr_q;

  assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_i)
    mem_strobe |=> !mem_strobe);
  assert_src_hold_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (src_req && !src_ack) |=> src_req);
  assert_cpu_idle_R11: assert property (@(posedge clk) disable iff (!rst_i)
    cpu_ack |-> !busy);
  assert_stat_full_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_P_WB) |=> (stat_q[FUL] == (stat_q[PW-1:0] == stat_q[2*PW-1:PW])));
endmodule

// File: tb/test_sds_seq.sv
module test_sds_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_req = 0, poll_dma = 0, poll_need = 0, src_ack = 0;
  logic cpu_we = 0, vec_rd = 0;
  logic [2:0]  poll_ch = 0;
  logic [15:0] src_data = 0, cpu_wdata = 0;
  logic [7:0]  cpu_addr = 0;
  logic busy, smp_valid, mem_strobe, src_req, cpu_ack, irq;
  logic [15:0] smp_data;
  logic [9:0]  stat_word;
  logic [23:0] src_addr;
  logic [7:0]  vec_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] mdl [256];
  logic [7:0]  m_vec = 0;
  logic        m_irq = 0;
  logic [15:0] m_smp = 0;

  always #2 clk = ~clk;

  sds_seq i_sds_seq (
    .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .poll_ch(poll_ch), .poll_dma(poll_dma),
    .poll_need(poll_need), .busy(busy), .smp_data(smp_data), .smp_valid(smp_valid),
    .stat_word(stat_word), .mem_strobe(mem_strobe), .src_req(src_req), .src_addr(src_addr),
    .src_ack(src_ack), .src_data(src_data), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .vec_rd(vec_rd), .vec_data(vec_data), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int fa(input int c, input int p); return c * 32 + p; endfunction
  function automatic int pa(input int c, input int i); return c * 32 + 16 + i; endfunction

  task automatic cpu_wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cpu_we = 1;  cpu_addr = 8'(a);  cpu_wdata = d;
    mdl[a] = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic poll(input int c, input bit dma, input bit need, input logic [15:0] sw);
    logic [15:0] st;
    logic [3:0]  rd, wr, wr_old;
    logic        tg, hit;
    logic [23:0] a, last;
    int strobes, valids;
    bit acked;
    st = mdl[pa(c, 0)];  rd = st[3:0];  wr = st[7:4];  tg = st[9];
    a = {mdl[pa(c, 2)][7:0], mdl[pa(c, 1)]};
    last = {mdl[pa(c, tg ? 6 : 4)][7:0], mdl[pa(c, tg ? 5 : 3)]};
    hit = 0;
    if (!dma || need) m_smp = mdl[fa(c, rd)];
    if (!dma) rd = rd + 1;
    else begin
      hit = (a == last);
      rd = rd + 4'(need);
      wr_old = wr;  wr = wr + 1;
      tg = tg ^ hit;
      mdl[fa(c, wr_old)] = sw;
      mdl[pa(c, 1)] = 16'((a + 24'd1) & 24'hFFFF);
      mdl[pa(c, 2)] = {8'h00, 8'((a + 24'd1) >> 16)};
      if (hit && !m_irq) begin
        m_vec = {3'b000, 3'(c), tg, 1'b0};
        m_irq = 1;
      end
    end
    mdl[pa(c, 0)] = {6'b0, tg, rd == wr, wr, rd};

    @(negedge clk);
    poll_req = 1;  poll_ch = 3'(c);  poll_dma = dma;  poll_need = need;
    @(negedge clk);
    poll_req = 0;
    // a CPU write while busy must be refused (R11)
    cpu_we = 1;  cpu_addr = 8'(fa(7, 15));  cpu_wdata = 16'hDEAD;
    #1 chk(cpu_ack == 0, "R11 cpu_ack while busy", 32'(cpu_ack), 0);
    cpu_we = 0;
    strobes = 0;  valids = 0;  acked = 0;
    forever begin
      if (mem_strobe) strobes++;
      if (smp_valid) valids++;
      if (src_req && !src_ack) begin
        chk(dma && src_addr == a, "R4 src_addr", 32'(src_addr), 32'(a));
        src_ack = 1;  src_data = sw;  acked = 1;
      end else src_ack = 0;
      if (!busy) break;
      @(negedge clk);
    end
    chk(strobes == (dma ? 1 : 0), "R4 strobe count", 32'(strobes), dma ? 1 : 0);
    chk(valids == ((!dma || need) ? 1 : 0), "R5 smp_valid count", 32'(valids), (!dma || need) ? 1 : 0);
    chk(acked == dma, "R8 source request", 32'(acked), 32'(dma));
    chk(smp_data == m_smp, "R2 smp_data", 32'(smp_data), 32'(m_smp));
    chk(stat_word == mdl[pa(c, 0)][9:0], dma ? "R7 R9 stat_word refill" : "R3 stat_word plain",
        32'(stat_word), 32'(mdl[pa(c, 0)][9:0]));
    chk(irq == m_irq, "R10 irq", 32'(irq), 32'(m_irq));
    chk(vec_data == m_vec, "R6 R10 vec_data", 32'(vec_data), 32'(m_vec));
  endtask

  task automatic read_vec();
    @(negedge clk);
    chk(vec_data == m_vec, "R10 vec before read", 32'(vec_data), 32'(m_vec));
    vec_rd = 1;
    @(negedge clk);
    vec_rd = 0;
    m_irq = 0;
    chk(irq == 0, "R10 irq cleared by vec_rd", 32'(irq), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && irq == 0 && smp_valid == 0 && src_req == 0 && mem_strobe == 0,
        "R1 reset controls", {busy, irq, smp_valid, src_req, mem_strobe}, 0);
    chk(vec_data == 0 && smp_data == 0 && stat_word == 0, "R1 reset data",
        {vec_data, smp_data}, 0);

    // fill the RAM: FIFO pattern, zero status, distinct addresses, unreachable last
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 16; p++) cpu_wr(fa(c, p), 16'(c * 256 + p + 16'h1000));
      cpu_wr(pa(c, 0), 0);
      cpu_wr(pa(c, 1), 16'(16'hFFF0 + c));
      cpu_wr(pa(c, 2), 16'(c));
      for (int i = 3; i < 7; i++) cpu_wr(pa(c, i), 16'h00FF);
      for (int i = 7; i < 16; i++) cpu_wr(pa(c, i), 0);
    end
    @(negedge clk);
    cpu_we = 1;  cpu_addr = 8'(pa(3, 1));  cpu_wdata = 16'hFFFF;  mdl[pa(3, 1)] = 16'hFFFF;
    #1 chk(cpu_ack == 1, "R11 cpu_ack when idle", 32'(cpu_ack), 1);
    @(negedge clk);
    cpu_we = 0;
    cpu_wr(pa(3, 2), 16'h0012);
    cpu_wr(pa(3, 3), 16'h0001);  cpu_wr(pa(3, 4), 16'h0013);
    cpu_wr(pa(3, 5), 16'h0002);  cpu_wr(pa(3, 6), 16'h0013);

    poll(3, 1, 0, 16'hA001);   // R8: stored at wr 0, address carries 0x12FFFF->0x130000
    poll(3, 1, 1, 16'hA002);   // R5: sample read within refill
    poll(3, 0, 0, 16'h0);      // R2/R3: plain read, pointers meet
    poll(3, 1, 0, 16'hA003);   // R6/R9/R10: last hit on pair 0
    poll(3, 1, 0, 16'hA004);   // R10: last hit on pair 1 while pending
    read_vec();
    cpu_wr(pa(5, 1), 16'h0100);  cpu_wr(pa(5, 2), 16'h0000);
    cpu_wr(pa(5, 3), 16'h0100);  cpu_wr(pa(5, 4), 16'h0000);
    poll(5, 1, 1, 16'hB001);
    read_vec();

    for (int n = 0; n < 80; n++) begin
      int c;
      bit d, nd;
      c = $urandom_range(0, 7);  d = 1'($urandom_range(0, 1));  nd = 1'($urandom_range(0, 1));
      poll(c, d, nd, 16'($urandom));
      if ($urandom_range(0, 9) == 0) read_vec();
    end
    for (int p = 0; p < 20; p++) poll(7, 0, 0, 16'h0);  // R11: refused write must not appear

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule